// File: doc/BRIEF.md
# Dual-Lane Byte Serial Transmitter

This block is a serial bus master that moves a run of 8-bit words over a clock line, a data-out line and an auxiliary data line, with two select outputs for two attached devices. A host sets the mode inputs, the byte count and the clock divider, then pulses `start`. The block raises `busy`, asks for each transmit byte in turn, clocks it out most significant bit first, samples the returned byte from `miso`, and pulses `done` once the run is over. In normal mode one bit leaves per serial clock. In fast mode two bits leave per serial clock, the second one on the auxiliary line.

A verify mode checks the contents of the device. In this mode the block sends zeros, compares each returned byte with the byte the host offers on `tx_data`, and ends the run at the first byte that differs. `match_cnt` then tells how many bytes agreed. The serial clock runs at the input clock divided by 2·(d+1), where d is the divider value. A divider value of zero is raised to one, because the first sample taken at that speed cannot be trusted.

The control is a single state machine with six states. ST_IDLE waits for `start`. It goes to ST_LOAD, or straight to ST_FINISH when the byte count is zero. ST_LOAD latches the next byte and moves to ST_LOW. ST_LOW holds the clock low for one half period and then moves to ST_HIGH. ST_HIGH holds the clock high for one half period, then returns to ST_LOW while bits of the byte remain, and otherwise goes to ST_BYTE_END. ST_BYTE_END presents the received byte. It goes to ST_FINISH on a verify mismatch or after the last byte, and otherwise back to ST_LOAD. ST_FINISH releases both selects, pulses `done` and returns to ST_IDLE.

Top module: `dlane_byte_tx`

## Requirements
- R1: In normal mode each byte takes 8 serial clock pulses. Bit 7 goes first on `mosi`, and each bit is presented while `sclk` is low and held through the following high phase.
- R2: In fast mode each byte takes 4 serial clock pulses. The bit pairs go out in the order (7,6), (5,4), (3,2), (1,0): the higher bit of each pair on `mosi` and the lower bit on `aux`. In normal mode `aux` stays low.
- R3: Selects are active low. A device index of 2 asserts `sel_b_n`, and any other index asserts `sel_a_n`. The select not chosen stays high, and both are never low together.
- R4: When `sel_high` is set at start, neither select is driven low during the run.
- R5: When `done` pulses, both selects are high and `sclk` is low, and no serial clock pulse follows until the next start.
- R6: `miso` is sampled at each rising edge of `sclk` into a shift register, first sample at bit 7. After each byte, `rx_valid` pulses for one cycle with that byte on `rx_data` (normal mode).
- R7: In verify mode `mosi` carries only zeros. Each received byte is compared with `tx_data`. The run ends after the first byte that differs, and `match_cnt` holds the number of bytes that agreed, not counting the differing one.
- R8: Each half period of `sclk` lasts d+1 input clock cycles, where d is `div_in` latched at start.
- R9: A `div_in` of 0 behaves as 1, so each half period lasts 2 cycles.
- R10: `start` is taken only in ST_IDLE. `busy` is high from the cycle after start until `done`. `done` is a one-cycle pulse, after which `busy` is low. A `start` while busy has no effect.
- R11: A byte count of 0 produces `done` with no serial clock pulse and `match_cnt` = 0.
- R12: `data_take` pulses once per byte, in the cycle after `tx_data` has been latched, so that the host can then present the next byte.
- R13: Outside verify mode, `match_cnt` equals the byte count at `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken in ST_IDLE) |
| byte_cnt | input | CW | Number of bytes in the run |
| fast_mode | input | 1 | Two bits per serial clock |
| verify_mode | input | 1 | Send zeros and compare the returned bytes |
| sel_high | input | 1 | Keep both selects high during the run |
| dev_idx | input | 2 | Device index; 2 selects line B, others line A |
| div_in | input | DW | Clock divider value d |
| tx_data | input | 8 | Byte to send, or expected byte in verify mode |
| data_take | output | 1 | tx_data was consumed; present the next byte |
| miso | input | 1 | Serial data returned by the device |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out, higher bit of each pair |
| aux | output | 1 | Second data lane in fast mode |
| sel_a_n | output | 1 | Select line A, active low |
| sel_b_n | output | 1 | Select line B, active low |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | rx_data is a newly completed byte |
| match_cnt | output | CW | Bytes completed (or matched in verify mode) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Two decisions meet in ST_BYTE_END: the verify comparison and the check for the last byte. A mismatch on the final byte of a run therefore collides with normal completion. The bench provokes this with a three-byte verify run whose slave returns a wrong third byte. The expected result is `match_cnt` = 2, three `rx_valid` pulses and a normal `done`. A mismatch in the middle of a four-byte run is also checked. That run must stop after 16 clock pulses with `match_cnt` = 1.

// File: rtl/dlane_pkg.sv
package dlane_pkg;
    localparam int WORD_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LOW,
        ST_HIGH,
        ST_BYTE_END,
        ST_FINISH
    } dlane_state_e;
endpackage

// File: rtl/dlane_tick.sv
module dlane_tick #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] half_m1,
    output logic          last
);
    logic [DW-1:0] cnt;

    assign last = run && (cnt == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dlane_shreg.sv
module dlane_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         two,
    input  logic         sample,
    input  logic         din,
    output logic         tx_hi,
    output logic         tx_lo,
    output logic [W-1:0] rx_q
);
    logic [W-1:0] tx_q;

    assign tx_hi = tx_q[W-1];
    assign tx_lo = tx_q[W-2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tx_q <= '0;
        else if (load)
            tx_q <= load_val;
        else if (shift)
            tx_q <= two ? {tx_q[W-3:0], 2'b00} : {tx_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_q <= '0;
        else if (sample)
            rx_q <= {rx_q[W-2:0], din};
    end
endmodule

// File: rtl/dlane_selmap.sv
module dlane_selmap (
    input  logic       active,
    input  logic       sel_high,
    input  logic [1:0] dev_idx,
    output logic       sel_a_n,
    output logic       sel_b_n
);
    logic pick_b;

    assign pick_b  = (dev_idx == 2'd2);
    assign sel_a_n = !(active && !sel_high && !pick_b);
    assign sel_b_n = !(active && !sel_high && pick_b);
endmodule

// File: rtl/dlane_byte_tx.sv
module dlane_byte_tx
    import dlane_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CW-1:0]        byte_cnt,
    input  logic                 fast_mode,
    input  logic                 verify_mode,
    input  logic                 sel_high,
    input  logic [1:0]           dev_idx,
    input  logic [DW-1:0]        div_in,
    input  logic [WORD_BITS-1:0] tx_data,
    output logic                 data_take,
    input  logic                 miso,
    output logic                 sclk,
    output logic                 mosi,
    output logic                 aux,
    output logic                 sel_a_n,
    output logic                 sel_b_n,
    output logic [WORD_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic [CW-1:0]        match_cnt,
    output logic                 busy,
    output logic                 done
);
    localparam int BW = $clog2(WORD_BITS + 1);

    dlane_state_e st, st_nx;

    logic [CW-1:0]        left_q, match_q;
    logic [DW-1:0]        div_q;
    logic [WORD_BITS-1:0] exp_q, rx_q;
    logic [BW-1:0]        bits_q;
    logic [1:0]           dev_q;
    logic                 fast_q, ver_q, csh_q, take_q;
    logic                 run, last, in_frame, tx_hi, tx_lo, mismatch;

    assign run      = (st == ST_LOW) || (st == ST_HIGH);
    assign in_frame = (st == ST_LOAD) || run || (st == ST_BYTE_END);
    assign mismatch = ver_q && (rx_q != exp_q);

    dlane_tick #(.DW(DW)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .half_m1(div_q), .last(last)
    );

    dlane_shreg #(.W(WORD_BITS)) u_sh (
        .clk(clk), .rst_n(rst_n),
        .load(st == ST_LOAD),
        .load_val(ver_q ? '0 : tx_data),
        .shift((st == ST_HIGH) && last),
        .two(fast_q),
        .sample((st == ST_LOW) && last),
        .din(miso),
        .tx_hi(tx_hi), .tx_lo(tx_lo), .rx_q(rx_q)
    );

    dlane_selmap u_sel (
        .active(in_frame), .sel_high(csh_q), .dev_idx(dev_q),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:     if (start) st_nx = (byte_cnt == '0) ? ST_FINISH : ST_LOAD;
            ST_LOAD:     st_nx = ST_LOW;
            ST_LOW:      if (last) st_nx = ST_HIGH;
            ST_HIGH:     if (last) st_nx = (bits_q == BW'(1)) ? ST_BYTE_END : ST_LOW;
            ST_BYTE_END: st_nx = (mismatch || left_q == CW'(1)) ? ST_FINISH : ST_LOAD;
            ST_FINISH:   st_nx = ST_IDLE;
            default:     st_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q  <= '0;
            match_q <= '0;
            div_q   <= DW'(1);
            exp_q   <= '0;
            bits_q  <= '0;
            dev_q   <= '0;
            fast_q  <= 1'b0;
            ver_q   <= 1'b0;
            csh_q   <= 1'b0;
            take_q  <= 1'b0;
        end else begin
            take_q <= (st == ST_LOAD);
            unique case (st)
                ST_IDLE: if (start) begin
                    left_q  <= byte_cnt;
                    match_q <= '0;
                    div_q   <= (div_in == '0) ? DW'(1) : div_in;
                    dev_q   <= dev_idx;
                    fast_q  <= fast_mode;
                    ver_q   <= verify_mode;
                    csh_q   <= sel_high;
                end
                ST_LOAD: begin
                    exp_q  <= tx_data;
                    bits_q <= fast_q ? BW'(WORD_BITS / 2) : BW'(WORD_BITS);
                end
                ST_HIGH: if (last) bits_q <= bits_q - 1'b1;
                ST_BYTE_END: if (!mismatch) begin
                    match_q <= match_q + 1'b1;
                    left_q  <= left_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sclk      = (st == ST_HIGH);
        mosi      = run ? tx_hi : 1'b0;
        aux       = (run && fast_q) ? tx_lo : 1'b0;
        rx_valid  = (st == ST_BYTE_END);
        rx_data   = rx_q;
        data_take = take_q;
        match_cnt = match_q;
        busy      = (st != ST_IDLE);
        done      = (st == ST_FINISH);
    end

    a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        sel_a_n || sel_b_n);
    a_r5_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sel_a_n && sel_b_n && !sclk));
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    a_r2_aux_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_q |-> !aux);
    a_r1_clock_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (busy && !done));
    a_r9_min_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> $past(sclk, 2));
endmodule

// File: tb/sim_dlane_byte_tx.sv
module sim_dlane_byte_tx;
    logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] byte_cnt = '0, div_in = '0, tx_data = '0;
    logic       fast_mode = 0, verify_mode = 0, sel_high = 0;
    logic [1:0] dev_idx = '0;
    logic       data_take, miso, sclk, mosi, aux, sel_a_n, sel_b_n, rx_valid, busy, done;
    logic [7:0] rx_data, match_cnt;

    always #2 clk = ~clk;

    dlane_byte_tx u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
        .fast_mode(fast_mode), .verify_mode(verify_mode), .sel_high(sel_high),
        .dev_idx(dev_idx), .div_in(div_in), .tx_data(tx_data), .data_take(data_take),
        .miso(miso), .sclk(sclk), .mosi(mosi), .aux(aux), .sel_a_n(sel_a_n),
        .sel_b_n(sel_b_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .match_cnt(match_cnt), .busy(busy), .done(done)
    );

    int errs = 0, checks = 0;
    logic [7:0] tx_arr [0:7];
    logic [7:0] slv_arr [0:7];
    logic [7:0] got_arr [0:7];
    logic [7:0] exp_rx [$];
    logic [7:0] slv_sh = '0, cap = '0;
    int  tx_idx, slv_idx, slv_bits, cap_bits, got_n, rises, takes, hi_run, hi_meas;
    logic sclk_prev = 0, first_seen, snap_a, snap_b, aux_seen, cur_fast = 0, late_clk;

    assign miso = slv_sh[7];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // slave model and scoreboard monitor
    always @(negedge clk) begin
        if (data_take) begin
            takes++;
            tx_idx++;
            tx_data = tx_arr[tx_idx % 8];
        end
        if (rx_valid && !cur_fast) begin
            if (exp_rx.size() == 0) chk(0, "R6 unexpected rx", rx_data, 0);
            else begin
                logic [7:0] e;
                e = exp_rx.pop_front();
                chk(rx_data == e, "R6 rx byte", rx_data, e);
            end
        end
        if (sclk && !sclk_prev) begin
            rises++;
            if (!busy) late_clk = 1;
            if (!first_seen) begin first_seen = 1; snap_a = sel_a_n; snap_b = sel_b_n; end
            if (aux) aux_seen = 1;
            if (cur_fast) begin cap = {cap[5:0], mosi, aux}; cap_bits += 2; end
            else          begin cap = {cap[6:0], mosi};      cap_bits += 1; end
            if (cap_bits == 8) begin got_arr[got_n % 8] = cap; got_n++; cap_bits = 0; end
            slv_sh = slv_sh << 1;
            slv_bits++;
            if (slv_bits == 8) begin slv_idx++; slv_sh = slv_arr[slv_idx % 8]; slv_bits = 0; end
        end
        if (sclk) hi_run++;
        else if (sclk_prev) begin
            if (hi_meas == 0) hi_meas = hi_run;
            hi_run = 0;
        end
        sclk_prev = sclk;
    end

    task automatic run_xfer(input int n, input bit f, input bit v, input bit ch,
                            input logic [1:0] dv, input logic [7:0] dd, input bit poke);
        int k;
        int nrx;
        k = n;
        for (int i = 0; i < n; i++)
            if (v && k == n && slv_arr[i] != tx_arr[i]) k = i;
        nrx = (k < n) ? k + 1 : n;
        exp_rx.delete();
        if (!f) for (int i = 0; i < nrx; i++) exp_rx.push_back(slv_arr[i]);
        @(negedge clk);
        cur_fast = f; fast_mode = f; verify_mode = v; sel_high = ch; dev_idx = dv; div_in = dd;
        byte_cnt = 8'(n);
        tx_idx = 0; tx_data = tx_arr[0]; slv_idx = 0; slv_bits = 0; slv_sh = slv_arr[0];
        cap_bits = 0; got_n = 0; rises = 0; takes = 0; hi_run = 0; hi_meas = 0;
        first_seen = 0; aux_seen = 0; late_clk = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 1, "R10 busy after start", busy, 1);
        for (int c = 0; c < 20000 && !done; c++) begin
            @(negedge clk);
            if (poke && c == 10) begin start = 1; byte_cnt = 8'd9; end
            else start = 0;
        end
        start = 0;
        chk(done == 1, "R10 done seen", done, 1);
        chk(sel_a_n && sel_b_n, "R5 selects idle at done", {sel_a_n, sel_b_n}, 3);
        chk(exp_rx.size() == 0, "R6 all rx bytes seen", exp_rx.size(), 0);
        @(negedge clk);
        chk(!busy && !done, "R10 done one cycle", {busy, done}, 0);
        repeat (6) @(negedge clk);
        chk(!late_clk && sclk == 0, "R5 no clock after done", late_clk, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !sclk, "R10 reset idle", {busy, done, sclk}, 0);
        chk(sel_a_n && sel_b_n, "R3 reset selects high", {sel_a_n, sel_b_n}, 3);

        // normal mode, device 0, divider 0 forced to 1
        tx_arr = '{8'hA5, 8'h3C, 8'h0F, 0, 0, 0, 0, 0};
        slv_arr = '{8'h5A, 8'hC3, 8'h81, 0, 0, 0, 0, 0};
        run_xfer(3, 0, 0, 0, 2'd0, 8'd0, 0);
        chk(rises == 24, "R1 eight pulses per byte", rises, 24);
        chk(got_arr[0] == 8'hA5 && got_arr[1] == 8'h3C && got_arr[2] == 8'h0F,
            "R1 msb first", got_arr[1], 8'h3C);
        chk(!aux_seen, "R2 aux low in normal mode", aux_seen, 0);
        chk(snap_a == 0 && snap_b == 1, "R3 device 0 on line A", {snap_a, snap_b}, 1);
        chk(hi_meas == 2, "R9 zero divider as one", hi_meas, 2);
        chk(match_cnt == 3, "R13 count equals bytes", match_cnt, 3);
        chk(takes == 3, "R12 one take per byte", takes, 3);

        // fast mode, device 2, divider 3, stray start mid-run
        tx_arr = '{8'hB4, 8'h6D, 0, 0, 0, 0, 0, 0};
        run_xfer(2, 1, 0, 0, 2'd2, 8'd3, 1);
        chk(rises == 8, "R2 four pulses per byte", rises, 8);
        chk(got_arr[0] == 8'hB4 && got_arr[1] == 8'h6D, "R2 pair order", got_arr[0], 8'hB4);
        chk(snap_a == 1 && snap_b == 0, "R3 device 2 on line B", {snap_a, snap_b}, 2);
        chk(hi_meas == 4, "R8 half period d+1", hi_meas, 4);
        chk(match_cnt == 2, "R10 start while busy ignored", match_cnt, 2);

        // select-high option
        tx_arr = '{8'hC6, 0, 0, 0, 0, 0, 0, 0};
        slv_arr = '{8'h77, 0, 0, 0, 0, 0, 0, 0};
        run_xfer(1, 0, 0, 1, 2'd1, 8'd1, 0);
        chk(snap_a == 1 && snap_b == 1, "R4 selects stay high", {snap_a, snap_b}, 3);
        chk(got_arr[0] == 8'hC6, "R1 byte with select-high", got_arr[0], 8'hC6);

        // verify all match
        tx_arr = '{8'h11, 8'h22, 8'h33, 0, 0, 0, 0, 0};
        slv_arr = '{8'h11, 8'h22, 8'h33, 0, 0, 0, 0, 0};
        run_xfer(3, 0, 1, 0, 2'd0, 8'd1, 0);
        chk(match_cnt == 3, "R7 all bytes match", match_cnt, 3);
        chk(got_arr[0] == 0 && got_arr[1] == 0 && got_arr[2] == 0, "R7 zeros sent",
            got_arr[1], 0);

        // verify mismatch in the middle
        tx_arr = '{8'h11, 8'h22, 8'h33, 8'h44, 0, 0, 0, 0};
        slv_arr = '{8'h11, 8'h2A, 8'h33, 8'h44, 0, 0, 0, 0};
        run_xfer(4, 0, 1, 0, 2'd0, 8'd1, 0);
        chk(match_cnt == 1, "R7 stop at mismatch", match_cnt, 1);
        chk(rises == 16, "R7 no clock after mismatch", rises, 16);

        // verify mismatch on the last byte
        tx_arr = '{8'h11, 8'h22, 8'h33, 0, 0, 0, 0, 0};
        slv_arr = '{8'h11, 8'h22, 8'h34, 0, 0, 0, 0, 0};
        run_xfer(3, 0, 1, 0, 2'd0, 8'd2, 0);
        chk(match_cnt == 2, "R7 last byte mismatch", match_cnt, 2);

        // empty run
        run_xfer(0, 0, 0, 0, 2'd0, 8'd1, 0);
        chk(rises == 0 && match_cnt == 0, "R11 empty run", rises, 0);

        // larger divider
        tx_arr = '{8'h96, 0, 0, 0, 0, 0, 0, 0};
        run_xfer(1, 0, 0, 0, 2'd0, 8'd5, 0);
        chk(hi_meas == 6, "R8 divider five", hi_meas, 6);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule